// File: doc/BRIEF.md
# Two-Wire Bus Byte-Memory Slave

This block is a slave on a two-wire serial bus (SCL clock, open-drain SDA data) that gives a master access to a byte-wide memory. A fast system clock oversamples both bus lines through two-flop synchronisers. Edge detectors on the synchronised lines find START, repeated START and STOP conditions, and a single state machine then moves through the transaction phases: device address, pointer high byte, pointer low byte, write data, and read data.

Every access goes through one 15-bit address pointer. The pointer keeps its value from one transaction to the next. It advances once per data byte, at the point where the byte has been fully transferred and before the acknowledge slot. When it passes 7FFFh it continues at 0000h. A write that carries only the two pointer bytes positions the pointer. A repeated START followed by a read address then gives a random read. A read that opens a new transaction continues from wherever the pointer stands.

The block also recognises a high-speed master code that the master sends directly after a START. It reports high-speed mode on a status output until the next STOP. The storage array holds 2^MEM_AW bytes and is addressed by the low bits of the pointer. SDA is never driven high. The block asserts `sda_oe` to pull the line low.

Top module: `twm_slave`

## Requirements
- R1: A byte received right after START whose bits 7..4 equal 1010b and whose bits 3..1 equal `dev_sel` is acknowledged: `sda_oe` is high during the ninth SCL clock. Bit 0 set to 1 selects a read and bit 0 set to 0 selects a write.
- R2: After an address byte that does not match, the block does not assert `sda_oe` at all until the next START, and the memory contents stay unchanged.
- R3: In a write, the two bytes after the address are the pointer, high byte first. Both bytes are acknowledged. Bit 7 of the high byte is ignored, and the remaining 15 bits are loaded into the pointer.
- R4: Each later write data byte is acknowledged and stored at the pointer. The pointer then increments before the acknowledge slot.
- R5: The pointer goes from 7FFFh to 0000h on increment. Storage location = pointer modulo 2^MEM_AW (1024 bytes by default), so a burst crosses the wrap without a break.
- R6: A read returns the byte at the pointer, most significant bit first, with `sda_oe` changing only while SCL is low. The pointer keeps its value across STOP, so a later transaction that reads continues from it.
- R7: A write carrying only the two pointer bytes, followed by a repeated START and a read address, returns data from the new pointer value.
- R8: A master NACK after a read byte ends the read. SDA stays released for every following clock until the next START.
- R9: A byte 00001xxxb directly after START is not acknowledged and sets `hs_mode` to 1. `hs_mode` stays 1 through repeated STARTs and returns to 0 on STOP.
- R10: A START or STOP in the middle of a byte abandons that byte. After such a START, a valid address is accepted as usual.
- R11: After reset, `sda_oe` and `hs_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| dev_sel | input | 3 | Device-select value compared with address bits 3..1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| hs_mode | output | 1 | High-speed mode indicator |

## Verification
Two situations are the hardest to reach from the ports. The first is the pointer rolling over at 7FFFh inside a single burst. The bench reaches it by loading the pointer at 7FFEh, writing three bytes, and then reading the same three bytes back across the wrap. The second is a condition arriving in the middle of a byte, which needs a START or STOP placed between data bits. The bench drives partial bytes bit by bit, interrupts them, and then shows through a following normal transaction that the interrupted byte left no trace in memory and that the slave recovered. The high-speed master code is placed directly after a START and is followed by a repeated-START write. This confirms that the mode flag survives until the STOP.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DEVADDR = 3'd1,
        ST_PTR_HI  = 3'd2,
        ST_PTR_LO  = 3'd3,
        ST_WRITE   = 3'd4,
        ST_READ    = 3'd5,
        ST_SKIP    = 3'd6
    } twm_state_e;

    localparam logic [3:0] TWM_DEV_TYPE = 4'b1010;
    localparam logic [4:0] TWM_HS_CODE  = 5'b00001;

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;
    localparam int I_SCL  = 1;
    localparam int I_SDA  = 0;

    logic [NLINES-1:0] line_in;
    logic [NLINES-1:0] line_s;
    logic [NLINES-1:0] prev_q;

    assign line_in = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_in[g]};
        end
        assign line_s[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= line_s;
    end

    assign scl_s     = line_s[I_SCL];
    assign sda_s     = line_s[I_SDA];
    assign scl_rise  =  line_s[I_SCL] & ~prev_q[I_SCL];
    assign scl_fall  = ~line_s[I_SCL] &  prev_q[I_SCL];
    // conditions are only legal while SCL is high on both samples
    assign start_det = line_s[I_SCL] & prev_q[I_SCL] &  prev_q[I_SDA] & ~line_s[I_SDA];
    assign stop_det  = line_s[I_SCL] & prev_q[I_SCL] & ~prev_q[I_SDA] &  line_s[I_SDA];

endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/twm_slave.sv
module twm_slave
    import twm_pkg::*;
#(
    parameter int PTR_W       = 15,
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel,
    output logic       sda_oe,
    output logic       hs_mode
);
    localparam int HI_W = PTR_W - 8;

    typedef struct packed {
        twm_state_e       st;
        logic [3:0]       bitcnt;
        logic [7:0]       sr;
        logic             oe;
        logic             rw;
        logic             ack;
        logic             hs;
        logic [PTR_W-1:0] ptr;
        logic [HI_W-1:0]  hi;
    } twm_regs_t;

    twm_regs_t q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] byte_in;
    logic [7:0] mem_rdata;
    logic [7:0] mem_wdata;
    logic       mem_we;

    // names seen by the bound checker
    twm_state_e       st_q;
    logic [3:0]       bitcnt_q;
    logic [PTR_W-1:0] ptr_q;
    assign st_q     = q.st;
    assign bitcnt_q = q.bitcnt;
    assign ptr_q    = q.ptr;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twm_mem #(.AW(MEM_AW), .DW(8)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (q.ptr[MEM_AW-1:0]),
        .wdata (mem_wdata),
        .raddr (q.ptr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    assign byte_in = {q.sr[6:0], sda_s};

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_wdata = '0;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.hs     = 1'b0;
            d.bitcnt = '0;
        end else if (start_det) begin
            d.st     = ST_DEVADDR;
            d.oe     = 1'b0;
            d.bitcnt = '0;
        end else begin
            unique case (q.st)
                ST_IDLE, ST_SKIP: begin
                    d = q;
                end
                ST_READ: begin
                    if (scl_rise) begin
                        if (q.bitcnt < 4'd8) begin
                            d.bitcnt = q.bitcnt + 4'd1;
                        end else if (q.bitcnt == 4'd8) begin
                            if (sda_s) begin
                                d.st     = ST_SKIP;   // master NACK
                                d.bitcnt = '0;
                            end else begin
                                d.bitcnt = 4'd9;
                            end
                        end
                    end else if (scl_fall) begin
                        if (q.bitcnt >= 4'd1 && q.bitcnt <= 4'd7) begin
                            d.sr = {q.sr[6:0], 1'b0};
                            d.oe = ~q.sr[6];
                        end else if (q.bitcnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + PTR_W'(1);
                        end else if (q.bitcnt == 4'd9) begin
                            d.sr     = mem_rdata;
                            d.oe     = ~mem_rdata[7];
                            d.bitcnt = '0;
                        end
                    end
                end
                default: begin
                    if (scl_rise) begin
                        if (q.bitcnt < 4'd8) begin
                            d.sr     = byte_in;
                            d.bitcnt = q.bitcnt + 4'd1;
                            if (q.bitcnt == 4'd7) begin
                                d.ack = 1'b1;
                                case (q.st)
                                    ST_DEVADDR: begin
                                        if (byte_in[7:3] == TWM_HS_CODE) begin
                                            d.hs  = 1'b1;
                                            d.ack = 1'b0;
                                            d.st  = ST_SKIP;
                                        end else if (byte_in[7:4] == TWM_DEV_TYPE &&
                                                     byte_in[3:1] == dev_sel) begin
                                            d.rw = byte_in[0];
                                        end else begin
                                            d.ack = 1'b0;
                                            d.st  = ST_SKIP;
                                        end
                                    end
                                    ST_PTR_HI: d.hi  = byte_in[HI_W-1:0];
                                    ST_PTR_LO: d.ptr = {q.hi, byte_in};
                                    ST_WRITE: begin
                                        mem_we    = 1'b1;
                                        mem_wdata = byte_in;
                                        d.ptr     = q.ptr + PTR_W'(1);
                                    end
                                    default: d.ack = 1'b0;
                                endcase
                            end
                        end else if (q.bitcnt == 4'd8) begin
                            d.bitcnt = 4'd9;
                        end
                    end else if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe = q.ack;
                        end else if (q.bitcnt == 4'd9) begin
                            d.oe     = 1'b0;
                            d.bitcnt = '0;
                            case (q.st)
                                ST_DEVADDR: begin
                                    if (q.rw) begin
                                        d.st = ST_READ;
                                        d.sr = mem_rdata;
                                        d.oe = ~mem_rdata[7];
                                    end else begin
                                        d.st = ST_PTR_HI;
                                    end
                                end
                                ST_PTR_HI: d.st = ST_PTR_LO;
                                ST_PTR_LO: d.st = ST_WRITE;
                                default:   d.st = q.st;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe  = q.oe;
    assign hs_mode = q.hs;

endmodule

// File: rtl/twm_slave_checks.sv
module twm_slave_checks
    import twm_pkg::*;
#(
    parameter int PTR_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             stop_det,
    input logic             sda_oe,
    input logic             hs_mode,
    input twm_state_e       st_q,
    input logic [3:0]       bitcnt_q,
    input logic [PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] PTR_MAX = '1;

    assert_oe_steady_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    assert_stop_clears_hs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!hs_mode && !sda_oe));

    assert_silent_unselected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE || st_q == ST_SKIP) |-> !sda_oe);

    assert_ack_only_in_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && st_q != ST_READ) |-> (bitcnt_q >= 4'd8));

    assert_pointer_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q) && $past(ptr_q) == PTR_MAX && $past(st_q) != ST_PTR_LO)
        |-> (ptr_q == '0));

endmodule

bind twm_slave twm_slave_checks #(.PTR_W(PTR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .hs_mode  (hs_mode),
    .st_q     (st_q),
    .bitcnt_q (bitcnt_q),
    .ptr_q    (ptr_q)
);

// File: tb/twm_slave_tb.sv
`timescale 1ns/1ps
module twm_slave_tb;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;
    localparam int Q = 8;
    localparam logic [2:0] DEV = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, hs_mode;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    twm_slave #(.PTR_W(15), .MEM_AW(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .dev_sel(DEV), .sda_oe(sda_oe), .hs_mode(hs_mode)
    );

    int n_chk = 0;
    int n_fail = 0;
    int oe_cnt = 0;
    bit reported = 0;
    logic [7:0] model [DEPTH];
    logic [14:0] mptr;
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string req_q [$];

    always @(posedge clk) if (sda_oe) oe_cnt <= oe_cnt + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(2 * Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        b = sda_line; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(r);
        acked = ~r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(r);
            v[i] = r;
        end
        send_bit(~give_ack);
    endtask

    task automatic wr_body(input logic [15:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                           input logic [7:0] d2, input int n);
        logic a;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        send_byte({4'b1010, DEV, 1'b0}, a); chk("R1 write address ack", a, 1);
        send_byte(addr[15:8], a);           chk("R3 high pointer ack", a, 1);
        send_byte(addr[7:0], a);            chk("R3 low pointer ack", a, 1);
        mptr = addr[14:0];
        for (int i = 0; i < n; i++) begin
            send_byte(dv[i], a); chk("R4 data ack", a, 1);
            model[mptr[AW-1:0]] = dv[i];
            mptr = mptr + 15'd1;
        end
    endtask

    task automatic rd_body(input int n, input string req);
        logic a;
        logic [7:0] v;
        send_byte({4'b1010, DEV, 1'b1}, a); chk("R1 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[mptr[AW-1:0]]);
            req_q.push_back(req);
            mptr = mptr + 15'd1;
            recv_byte(i < n - 1, v);
            got_q.push_back(v);
        end
        hold(Q);
        chk("R8 SDA released after NACK", sda_oe, 0);
    endtask

    task automatic mem_write(input logic [15:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                             input logic [7:0] d2, input int n);
        bus_start();
        wr_body(addr, d0, d1, d2, n);
        bus_stop();
    endtask

    task automatic rand_read(input logic [15:0] addr, input int n, input string req);
        bus_start();
        wr_body(addr, 8'h00, 8'h00, 8'h00, 0);
        bus_start();
        rd_body(n, req);
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        bus_start();
        rd_body(n, req);
        bus_stop();
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (got_q.size() > 0);
            chk(req_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        logic a;
        logic r;
        int c0;
        hold(10);
        rst_n = 1'b1;
        hold(10);
        chk("R11 sda_oe after reset", sda_oe, 0);
        chk("R11 hs_mode after reset", hs_mode, 0);

        // burst write and random read
        mem_write(16'h0010, 8'h11, 8'h22, 8'h33, 3);
        rand_read(16'h0010, 3, "R7 random read burst");

        // wrong device type, then wrong select value carrying a write
        c0 = oe_cnt;
        bus_start();
        send_byte({4'b1011, DEV, 1'b0}, a); chk("R2 wrong type not acked", a, 0);
        send_byte(8'h00, a);
        bus_stop();
        bus_start();
        send_byte({4'b1010, 3'b001, 1'b0}, a); chk("R2 wrong select not acked", a, 0);
        send_byte(8'h00, a);
        send_byte(8'h10, a);
        send_byte(8'hEE, a);
        bus_stop();
        hold(Q);
        chk("R2 no SDA drive while unselected", oe_cnt - c0, 0);
        rand_read(16'h0010, 1, "R2 memory untouched");

        // current-address read continues after STOP (pointer now 0011h)
        cur_read(2, "R6 current address read");

        // rollover across 7FFFh
        mem_write(16'h7FFE, 8'hAA, 8'hBB, 8'hCC, 3);
        rand_read(16'h7FFE, 3, "R5 read across wrap");
        rand_read(16'h0000, 1, "R5 wrapped byte at 0000h");

        // MSB of high pointer byte ignored
        mem_write(16'h8020, 8'h5A, 8'h00, 8'h00, 1);
        rand_read(16'h0020, 1, "R3 pointer bit 15 ignored");

        // after NACK the line stays released
        rand_read(16'h0010, 1, "R8 single read");
        bus_start();
        send_byte({4'b1010, DEV, 1'b1}, a);
        begin
            logic [7:0] v;
            recv_byte(1'b0, v);
        end
        c0 = oe_cnt;
        for (int i = 0; i < 8; i++) begin
            recv_bit(r);
            chk("R8 line high after NACK", r, 1);
        end
        chk("R8 no drive after NACK", oe_cnt - c0, 0);
        bus_stop();

        // high-speed master code
        bus_start();
        send_byte(8'b0000_1011, a);
        chk("R9 master code not acked", a, 0);
        chk("R9 hs_mode set", hs_mode, 1);
        bus_start();
        wr_body(16'h0030, 8'h77, 8'h00, 8'h00, 1);
        chk("R9 hs_mode held through repeated START", hs_mode, 1);
        bus_stop();
        hold(Q);
        chk("R9 hs_mode cleared by STOP", hs_mode, 0);
        rand_read(16'h0030, 1, "R9 write in high-speed mode");

        // START in the middle of an address byte
        bus_start();
        for (int i = 0; i < 4; i++) send_bit(i[0]);
        bus_start();
        wr_body(16'h0040, 8'h99, 8'h00, 8'h00, 1);
        bus_stop();
        rand_read(16'h0040, 1, "R10 recovery after START mid-byte");

        // START in the middle of a data byte: byte must not land
        bus_start();
        wr_body(16'h0050, 8'h12, 8'h00, 8'h00, 1);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_start();
        wr_body(16'h0060, 8'h34, 8'h00, 8'h00, 1);
        bus_stop();
        rand_read(16'h0050, 1, "R10 complete byte kept");
        model[AW'(16'h0051)] = 8'h00;
        rand_read(16'h0060, 1, "R10 write after abort");

        // STOP in the middle of a byte
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        bus_stop();
        hold(Q);
        chk("R10 released after STOP mid-byte", sda_oe, 0);
        cur_read(1, "R10 current read after STOP abort");

        wait (got_q.size() == 0);
        hold(4);
        report();
    end

endmodule